// File: doc/BRIEF.md
# Rewindable Word FIFO with Occupancy Flags

This block is a single-clock first-in/first-out buffer for 9-bit words, meant to sit between a producer and a consumer that run at independent rates but share one clock. The producer raises a write strobe with a word, and the consumer raises a read strobe. Both sides walk a ring-addressed array through internal pointers, so no address appears at the interface. With 9-bit words, a parity or control bit can travel alongside each byte.

Three registered flags report occupancy: empty, full and half-full. The flags stop the buffer from underflowing or overflowing. An active-low rewind input moves the read side back to the first location written since reset, so a packet can be read out again from its start. This is valid as long as no more than the buffer depth has been written since reset. A mode input selects stand-alone operation, where the half-full output is driven. When the mode input is low, that output is held low, as a chained configuration needs.

Top module: `rewind_fifo`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, then after that edge `empty` is 1, `full` is 0, `half_full` is 0, `rd_data` is 0, and both internal positions are back at the first location.
- R2: Words come out of `rd_data` in the order they were written, with all 9 bits intact. `rd_data` is registered and takes the new word at the same edge that accepts the read.
- R3: When the buffer is neither empty nor full and both strobes are high at an edge, the write and the read both take effect, and the occupancy is unchanged.
- R4: A write strobe at an edge where `full` is 1 has no effect: no word is stored and the write position does not move.
- R5: A read strobe at an edge where `empty` is 1 has no effect: `rd_data` keeps its value and the read position does not move.
- R6: After each edge, `empty` is 1 exactly when the occupancy is 0, and `full` is 1 exactly when the occupancy equals DEPTH.
- R7: With `solo_mode` = 1, `half_full` is 1 exactly when the occupancy after the last edge is greater than DEPTH/2.
- R8: With `solo_mode` = 0, `half_full` is 0 at all times.
- R9: When `rewind_n` is low at an edge:
  - the read position returns to the first location;
  - the occupancy becomes the number of words written since reset, counting a write accepted at that same edge;
  - a read strobe at that edge is ignored.
- R10: When no read is accepted at an edge, `rd_data` keeps its previous value.
- R11: DEPTH must be 256, 512 or 1024. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, active high |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe, active high |
| rd_data | output | 9 | Registered word read out |
| rewind_n | input | 1 | Retransmit request, active low |
| solo_mode | input | 1 | 1 = stand-alone (half-full driven), 0 = chained (half-full held low) |
| empty | output | 1 | Occupancy is zero |
| half_full | output | 1 | Occupancy above DEPTH/2 (stand-alone mode only) |
| full | output | 1 | Occupancy equals DEPTH |

## Verification
The bench applies several traffic patterns, and each one isolates a different fault:

- **Write bursts then read bursts.** Reading after a burst of writes shows ordering and data faults. Filling to the brim shows whether the full flag and the half-full threshold switch at exactly DEPTH and DEPTH/2 + 1.
- **Strobes against the flags.** Strobes held high against a full or an empty buffer, including both strobes at once while full, separate blocked accesses from accepted ones.
- **Rewinds.** Rewinds are issued after a partial drain, while a write happens at the same edge, and after exactly DEPTH writes. These show whether the occupancy is rebuilt from the write history rather than from the read count.
- **Mixed pseudo-random traffic.** A long stretch of mixed strobes, with the mode input toggled, exercises wrap-around of both pointers and the gating of the half-full output.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

    // Word width: eight payload bits plus one side bit.
    localparam int unsigned WORD_W = 9;

    // Supported buffer depths.
    function automatic bit depth_ok(input int unsigned d);
        return (d == 256) || (d == 512) || (d == 1024);
    endfunction

endpackage

// File: rtl/rf_ptr_ctrl.sv
module rf_ptr_ctrl #(
    parameter int unsigned DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     rewind_n,
    input  logic                     solo_mode,
    output logic                     wr_go,
    output logic                     rd_go,
    output logic [$clog2(DEPTH)-1:0] wr_idx,
    output logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic                     empty,
    output logic                     full,
    output logic                     half_full
);
    localparam int unsigned AW   = $clog2(DEPTH);
    localparam int unsigned HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW:0]   wp;    // writes since reset, modulo 2*DEPTH
        logic [AW-1:0] rp;    // read position
        logic [AW:0]   cnt;   // occupancy
        logic          emp;
        logic          ful;
        logic          hf;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_go = wr_en && !st_q.ful;
        rd_go = rd_en && !st_q.emp && rewind_n;

        st_d.wp = st_q.wp + {{AW{1'b0}}, wr_go};

        if (!rewind_n) begin
            st_d.rp  = '0;
            st_d.cnt = st_d.wp;
        end else begin
            st_d.rp  = st_q.rp + {{(AW-1){1'b0}}, rd_go};
            st_d.cnt = st_q.cnt + {{AW{1'b0}}, wr_go} - {{AW{1'b0}}, rd_go};
        end

        st_d.emp = (st_d.cnt == '0);
        st_d.ful = (st_d.cnt == (AW+1)'(DEPTH));
        st_d.hf  = (st_d.cnt > (AW+1)'(HALF));

        if (!rst_n) begin
            st_d     = '0;
            st_d.emp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wr_idx    = st_q.wp[AW-1:0];
    assign rd_idx    = st_q.rp;
    assign empty     = st_q.emp;
    assign full      = st_q.ful;
    assign half_full = st_q.hf && solo_mode;

    // R4: a write attempt against a full buffer leaves it full
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en && rewind_n |=> full);

    // R5: a read attempt against an empty buffer leaves it empty
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !wr_en && rewind_n |=> empty);

    // R6: the two extremes never coincide
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R3: a paired read and write keeps every flag where it was
    a_r3_paired_access: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && !full && wr_en && rd_en && rewind_n
        |=> $stable(empty) && $stable(full) && $stable(st_q.hf));

    // R7: above half implies not empty
    a_r7_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |-> !empty);

    // R8: chained mode never shows half-full
    a_r8_half_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !solo_mode |-> !half_full);

    // R9: a rewind puts the read position on the first location
    a_r9_rewind_start: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_n |=> rd_idx == '0);

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned W     = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_go,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic                     rd_go,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] dout_d, dout_q;

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        dout_d = dout_q;
        if (rd_go) begin
            dout_d = mem[rd_idx];
        end
        if (!rst_n) begin
            dout_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        dout_q <= dout_d;
    end

    assign rd_data = dout_q;

    // R10: without an accepted read the output word holds
    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));

    // R4: the array is never written at the location being read
    a_r4_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && rd_go |-> wr_idx != rd_idx);

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rewind_n,
    input  logic              solo_mode,
    output logic              empty,
    output logic              half_full,
    output logic              full
);
    localparam int unsigned AW = $clog2(DEPTH);

    // R11: only the supported depths elaborate
    generate
        if (!depth_ok(DEPTH)) begin : g_bad_depth
            $error("rewind_fifo: DEPTH must be 256, 512 or 1024");
        end
    endgenerate

    logic          wr_go, rd_go;
    logic [AW-1:0] wr_idx, rd_idx;

    rf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rewind_n  (rewind_n),
        .solo_mode (solo_mode),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    rf_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_go   (rd_go),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: tb/rewind_fifo_tb_top.sv
module rewind_fifo_tb_top;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [8:0] rd_data;
    logic       rewind_n = 1'b1;
    logic       solo_mode = 1'b1;
    logic       empty, half_full, full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [8:0] hist[$];
    int         rpos = 0;
    logic [8:0] exp_rd = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #10ns clk = ~clk;

    rewind_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rewind_n(rewind_n),
        .solo_mode(solo_mode), .empty(empty), .half_full(half_full), .full(full)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    // one clock: drive, let the edge pass, update the model, compare
    task automatic step(input bit rs, input bit w, input logic [8:0] wd,
                        input bit r, input bit rw, input bit solo);
        int occ;
        bit dw, dr;
        string t_rd, t_fl;
        rst_n = rs; wr_en = w; wr_data = wd; rd_en = r; rewind_n = rw; solo_mode = solo;
        @(posedge clk);
        t_fl = "R6";
        if (!rs) begin
            hist.delete(); rpos = 0; exp_rd = '0;
            t_rd = "R1"; t_fl = "R1";
        end else begin
            occ = hist.size() - rpos;
            dw = w && (occ < DEPTH);
            dr = r && (occ > 0) && rw;
            if (w && !dw) t_fl = "R4";
            if (!rw)           t_rd = "R9";
            else if (dr && dw) t_rd = "R3";
            else if (dr)       t_rd = "R2";
            else if (r)        t_rd = "R5";
            else               t_rd = "R10";
            if (dr) begin exp_rd = hist[rpos]; rpos++; end
            if (dw) hist.push_back(wd);
            if (!rw) rpos = 0;
        end
        occ = hist.size() - rpos;
        @(negedge clk);
        check(t_rd, "rd_data", int'(rd_data), int'(exp_rd));
        check(t_fl, "empty", int'(empty), int'(occ == 0));
        check(t_fl, "full", int'(full), int'(occ == DEPTH));
        if (!rs)        check("R1", "half_full", int'(half_full), 0);
        else if (solo)  check("R7", "half_full", int'(half_full), int'(occ > DEPTH/2));
        else            check("R8", "half_full", int'(half_full), 0);
    endtask

    function automatic logic [8:0] nextw();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[8:0];
    endfunction

    initial begin
        @(negedge clk);
        // R1: reset state
        step(0, 0, 0, 0, 1, 1);
        step(0, 1, 9'h1AA, 1, 1, 1);
        // R5: read while empty
        step(1, 0, 0, 1, 1, 1);
        // R2: a few writes then reads, including bit 8
        for (int i = 0; i < 5; i++) step(1, 1, 9'h100 | 9'(i * 37), 0, 1, 1);
        for (int i = 0; i < 2; i++) step(1, 0, 0, 1, 1, 1);
        // R3: paired accesses
        for (int i = 0; i < 4; i++) step(1, 1, nextw(), 1, 1, 1);
        // R6/R7: fill to the brim, R4: push against full
        for (int i = 0; i < DEPTH; i++) step(1, 1, nextw(), 0, 1, 1);
        for (int i = 0; i < 3; i++) step(1, 1, nextw(), 0, 1, 1);
        // R8: chained mode while more than half full
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 0);
        // both strobes while full: only the read is accepted
        step(1, 1, nextw(), 1, 1, 1);
        // drain and over-read
        for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, 1, 1, 1);
        // R9: rewind after partial drain, with a read at the same edge
        step(0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 10; i++) step(1, 1, nextw(), 0, 1, 1);
        for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 1, 1);
        step(1, 0, 0, 1, 0, 1);
        for (int i = 0; i < 12; i++) step(1, 0, 0, 1, 1, 1);
        // R9: rewind together with a write
        step(1, 1, nextw(), 0, 0, 1);
        for (int i = 0; i < 13; i++) step(1, 0, 0, 1, 1, 1);
        // R9: rewind after exactly DEPTH writes gives full again
        step(0, 0, 0, 0, 1, 1);
        for (int i = 0; i < DEPTH; i++) step(1, 1, nextw(), 0, 1, 1);
        for (int i = 0; i < 100; i++) step(1, 0, 0, 1, 1, 1);
        step(1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 1, 1);
        // mixed traffic with mode toggling, pointers wrap
        step(0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 3000; i++) begin
            logic [8:0] v;
            v = nextw();
            step(1, v[0] | v[3], nextw(), v[1] & (v[5] | v[6]), 1, (i % 500) < 400);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule